// File: doc/BRIEF.md
# Video Test Pattern Pixel Source

This block is the picture half of a synthetic video generator. A free-running interval timer produces a one-cycle frame-start pulse at a programmable period while the block is enabled. With the default 21-bit interval input, a count of 1666666 at 100 MHz gives a 60 Hz frame rate. In parallel, a pixel path turns any pixel coordinate into a 32-bit opaque colour word. The word depends on the selected pattern: one of five solid fills, an eight-bar colour chart, a foreground rectangle on a background, or a grey horizontal ramp.

A sequencer outside the block watches the frame-start pulse. It then walks x and y across the frame and forwards each returned word onto a video stream. The pixel word is registered, so it answers the coordinate and settings presented one clock earlier. A byte-order select swaps the red and blue lanes for sinks that expect the other channel order.

Top module: `vidpat_source`

## Requirements
- R1: During and immediately after reset, `frame_start_o` is 0 and `pixel_o` is 32'hFF000000.
- R2: While enabled, `frame_start_o` is high for exactly one cycle. With an effective interval N, it is high in the cycle that follows the N-th consecutive enabled clock edge, and again after every further N enabled edges.
- R3: No frame-start pulse is produced while `enable_i` is low. Every low-to-high transition of `enable_i` restarts the interval count from zero.
- R4: An `interval_i` value of 0 or 1 is treated as 2.
- R5: Pattern codes 0 to 4 fill every pixel with black 000000, white FFFFFF, red FF0000, green 00FF00 and blue 0000FF respectively (RGB hex).
- R6: Pattern code 5 draws colour bars. The bar number is x divided by (width/8), saturated at 7. Bars 0 to 7 are black 000000, red FF0000, orange FFA500, yellow FFFF00, green 00FF00, blue 0000FF, purple 800080 and white FFFFFF. A width below 8 makes every pixel white.
- R7: Pattern code 6 gives the foreground colour when ax ≤ x ≤ bx and ay ≤ y ≤ by, and the background colour otherwise. The range is empty when a corner lies beyond the other.
- R8: Pattern code 7 places the low 8 bits of x in all three colour channels.
- R9: Pattern codes above 7 give black.
- R10: `pixel_o` is registered. It reflects the inputs present at the previous clock edge, and its top byte [31:24] is always 8'hFF.
- R11: With `rgb_swap_i` = 0 the word is {alpha, red, green, blue} in bytes [31:24], [23:16], [15:8], [7:0]. With `rgb_swap_i` = 1 the red and blue bytes trade places.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Runs the interval timer |
| rgb_swap_i | input | 1 | Swaps red and blue byte lanes |
| mode_i | input | MODE_W | Pattern code |
| width_i | input | XW | Frame width in pixels |
| interval_i | input | IV_W | Frame period in clock cycles |
| x_i | input | XW | Pixel column |
| y_i | input | YW | Pixel row |
| corner_ax_i | input | XW | Rectangle first corner, column |
| corner_ay_i | input | YW | Rectangle first corner, row |
| corner_bx_i | input | XW | Rectangle second corner, column |
| corner_by_i | input | YW | Rectangle second corner, row |
| fg_rgb_i | input | 24 | Rectangle foreground colour, RGB |
| bg_rgb_i | input | 24 | Rectangle background colour, RGB |
| frame_start_o | output | 1 | One-cycle frame-start pulse |
| pixel_o | output | 32 | Registered colour word |

## Verification
The bench builds the block with XW = 8, YW = 4, MODE_W = 4 and IV_W = 5.

An 8-bit column lets the ramp be swept across all 256 levels. A 4-bit mode lets all sixteen codes be tried, including the eight unused ones. A 16×4 frame is covered for every code in both byte orders. Widths of 5, 8, 20 and 64 bring in the too-narrow case, uneven bar widths and columns past the last full bar.

A 5-bit interval makes periods 0 through 12 cheap to run for several frames each, including the clamped values. The timer is also interrupted part way through a count so that the restart can be seen.

// File: rtl/vidpat_pkg.sv
package vidpat_pkg;

    localparam int unsigned NUM_BARS  = 8;
    localparam int unsigned BAR_IDX_W = $clog2(NUM_BARS);
    localparam logic [7:0]  ALPHA_OPAQUE = 8'hFF;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    typedef enum logic [2:0] {
        PAT_BLACK = 3'd0,
        PAT_WHITE = 3'd1,
        PAT_RED   = 3'd2,
        PAT_GREEN = 3'd3,
        PAT_BLUE  = 3'd4,
        PAT_BARS  = 3'd5,
        PAT_RECT  = 3'd6,
        PAT_RAMP  = 3'd7
    } pat_e;

    localparam rgb_t RGB_BLACK  = 24'h000000;
    localparam rgb_t RGB_WHITE  = 24'hFFFFFF;
    localparam rgb_t RGB_RED    = 24'hFF0000;
    localparam rgb_t RGB_GREEN  = 24'h00FF00;
    localparam rgb_t RGB_BLUE   = 24'h0000FF;
    localparam rgb_t RGB_ORANGE = 24'hFFA500;
    localparam rgb_t RGB_YELLOW = 24'hFFFF00;
    localparam rgb_t RGB_PURPLE = 24'h800080;

    // Colour of each chart bar, leftmost first.
    function automatic rgb_t bar_colour(input logic [BAR_IDX_W-1:0] idx);
        rgb_t c;
        case (idx)
            3'd0:    c = RGB_BLACK;
            3'd1:    c = RGB_RED;
            3'd2:    c = RGB_ORANGE;
            3'd3:    c = RGB_YELLOW;
            3'd4:    c = RGB_GREEN;
            3'd5:    c = RGB_BLUE;
            3'd6:    c = RGB_PURPLE;
            default: c = RGB_WHITE;
        endcase
        return c;
    endfunction

    // Pack an opaque colour into the output word in the chosen lane order.
    function automatic logic [31:0] pack_word(input rgb_t c, input logic swap_rb);
        return swap_rb ? {ALPHA_OPAQUE, c.b, c.g, c.r}
                       : {ALPHA_OPAQUE, c.r, c.g, c.b};
    endfunction

    // Grey level replicated into every channel.
    function automatic rgb_t grey(input logic [7:0] lvl);
        rgb_t c;
        c.r = lvl;
        c.g = lvl;
        c.b = lvl;
        return c;
    endfunction

endpackage

// File: rtl/vidpat_frame_timer.sv
module vidpat_frame_timer #(
    parameter int unsigned IV_W = 21
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            enable_i,
    input  logic [IV_W-1:0] interval_i,
    output logic            strobe_o
);

    localparam logic [IV_W-1:0] MIN_IV = IV_W'(2);

    logic [IV_W-1:0] cnt_q;
    logic [IV_W-1:0] iv_eff;
    logic            wrap;
    logic            strobe_q;

    // Periods shorter than two cycles would hold the pulse high; clamp them.
    assign iv_eff = (interval_i < MIN_IV) ? MIN_IV : interval_i;
    assign wrap   = ({1'b0, cnt_q} + {{IV_W{1'b0}}, 1'b1}) >= {1'b0, iv_eff};

    always_ff @(posedge clk) begin
        if (rst || !enable_i) begin
            cnt_q    <= '0;
            strobe_q <= 1'b0;
        end else if (wrap) begin
            cnt_q    <= '0;
            strobe_q <= 1'b1;
        end else begin
            cnt_q    <= cnt_q + IV_W'(1);
            strobe_q <= 1'b0;
        end
    end

    assign strobe_o = strobe_q;

    // R2: a pulse never lasts two cycles
    assert_single_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        strobe_q |=> !strobe_q);

    // R3: no pulse follows an edge at which the timer was disabled
    assert_quiet_disabled_R3: assert property (@(posedge clk) disable iff (rst)
        !$past(enable_i) |-> !strobe_q);

    // R2: a pulse coincides with the restart of the count
    assert_pulse_restarts_R2: assert property (@(posedge clk) disable iff (rst)
        strobe_q |-> (cnt_q == '0));

endmodule

// File: rtl/vidpat_bar_index.sv
module vidpat_bar_index
    import vidpat_pkg::*;
#(
    parameter int unsigned XW = 12
) (
    input  logic [XW-1:0]        width_i,
    input  logic [XW-1:0]        x_i,
    output logic [BAR_IDX_W-1:0] idx_o
);

    localparam int unsigned NUM_THR = NUM_BARS - 1;

    logic [XW-1:0]      bar_w;
    logic [NUM_THR-1:0] past_thr;

    // Bar width is width/8; a column's bar is the number of bar edges it has
    // reached, which equals x/(width/8) saturated at the last bar.
    assign bar_w = width_i >> BAR_IDX_W;

    for (genvar k = 1; k <= NUM_THR; k++) begin : g_thr
        logic [XW+BAR_IDX_W-1:0] edge_col;
        assign edge_col       = (XW+BAR_IDX_W)'(k) * {{BAR_IDX_W{1'b0}}, bar_w};
        assign past_thr[k-1]  = {{BAR_IDX_W{1'b0}}, x_i} >= edge_col;
    end

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < NUM_THR; i++) begin
            idx_o = idx_o + BAR_IDX_W'(past_thr[i]);
        end
    end

endmodule

// File: rtl/vidpat_pixel_gen.sv
module vidpat_pixel_gen
    import vidpat_pkg::*;
#(
    parameter int unsigned XW     = 12,
    parameter int unsigned YW     = 12,
    parameter int unsigned MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              swap_rb_i,
    input  logic [XW-1:0]     width_i,
    input  logic [XW-1:0]     x_i,
    input  logic [YW-1:0]     y_i,
    input  logic [XW-1:0]     ax_i,
    input  logic [YW-1:0]     ay_i,
    input  logic [XW-1:0]     bx_i,
    input  logic [YW-1:0]     by_i,
    input  rgb_t              fg_i,
    input  rgb_t              bg_i,
    output logic [31:0]       pixel_o
);

    localparam logic [MODE_W-1:0] TOP_CODE = MODE_W'(7);
    localparam logic [31:0]       RST_WORD = {ALPHA_OPAQUE, 24'h000000};

    logic [BAR_IDX_W-1:0] bar_idx;
    logic                 in_rect;
    logic [7:0]           ramp_lvl;
    pat_e                 pat;
    rgb_t                 colour;
    logic [31:0]          pixel_q;

    vidpat_bar_index #(.XW(XW)) u_bar_index (
        .width_i (width_i),
        .x_i     (x_i),
        .idx_o   (bar_idx)
    );

    assign in_rect  = (x_i >= ax_i) && (x_i <= bx_i) && (y_i >= ay_i) && (y_i <= by_i);
    assign ramp_lvl = 8'(x_i);
    assign pat      = pat_e'(mode_i[2:0]);

    always_comb begin
        colour = RGB_BLACK;
        if (mode_i <= TOP_CODE) begin
            case (pat)
                PAT_BLACK: colour = RGB_BLACK;
                PAT_WHITE: colour = RGB_WHITE;
                PAT_RED:   colour = RGB_RED;
                PAT_GREEN: colour = RGB_GREEN;
                PAT_BLUE:  colour = RGB_BLUE;
                PAT_BARS:  colour = bar_colour(bar_idx);
                PAT_RECT:  colour = in_rect ? fg_i : bg_i;
                PAT_RAMP:  colour = grey(ramp_lvl);
                default:   colour = RGB_BLACK;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pixel_q <= RST_WORD;
        end else begin
            pixel_q <= pack_word(colour, swap_rb_i);
        end
    end

    assign pixel_o = pixel_q;

    // R10: alpha lane is always opaque
    assert_alpha_opaque_R10: assert property (@(posedge clk) disable iff (rst)
        pixel_q[31:24] == ALPHA_OPAQUE);

    // R8: ramp output is grey in either lane order
    assert_ramp_grey_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode_i) == TOP_CODE) |->
            (pixel_q[23:16] == pixel_q[15:8] && pixel_q[15:8] == pixel_q[7:0]));

    // R9: unused codes give black
    assert_high_code_black_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode_i) > TOP_CODE) |-> (pixel_q[23:0] == 24'h0));

    // R5: white fill covers all three channels
    assert_white_fill_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode_i) == MODE_W'(1)) |-> (pixel_q[23:0] == 24'hFFFFFF));

endmodule

// File: rtl/vidpat_source.sv
module vidpat_source
    import vidpat_pkg::*;
#(
    parameter int unsigned XW     = 12,
    parameter int unsigned YW     = 12,
    parameter int unsigned MODE_W = 4,
    parameter int unsigned IV_W   = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable_i,
    input  logic              rgb_swap_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [XW-1:0]     width_i,
    input  logic [IV_W-1:0]   interval_i,
    input  logic [XW-1:0]     x_i,
    input  logic [YW-1:0]     y_i,
    input  logic [XW-1:0]     corner_ax_i,
    input  logic [YW-1:0]     corner_ay_i,
    input  logic [XW-1:0]     corner_bx_i,
    input  logic [YW-1:0]     corner_by_i,
    input  logic [23:0]       fg_rgb_i,
    input  logic [23:0]       bg_rgb_i,
    output logic              frame_start_o,
    output logic [31:0]       pixel_o
);

    rgb_t fg;
    rgb_t bg;

    assign fg = rgb_t'(fg_rgb_i);
    assign bg = rgb_t'(bg_rgb_i);

    vidpat_frame_timer #(.IV_W(IV_W)) u_frame_timer (
        .clk        (clk),
        .rst        (rst),
        .enable_i   (enable_i),
        .interval_i (interval_i),
        .strobe_o   (frame_start_o)
    );

    vidpat_pixel_gen #(
        .XW     (XW),
        .YW     (YW),
        .MODE_W (MODE_W)
    ) u_pixel_gen (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode_i),
        .swap_rb_i (rgb_swap_i),
        .width_i   (width_i),
        .x_i       (x_i),
        .y_i       (y_i),
        .ax_i      (corner_ax_i),
        .ay_i      (corner_ay_i),
        .bx_i      (corner_bx_i),
        .by_i      (corner_by_i),
        .fg_i      (fg),
        .bg_i      (bg),
        .pixel_o   (pixel_o)
    );

endmodule

// File: tb/test_vidpat_source.sv
module test_vidpat_source;

    localparam int XW = 8;
    localparam int YW = 4;
    localparam int MODE_W = 4;
    localparam int IV_W = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic swap = 1'b0;
    logic [MODE_W-1:0] mode = '0;
    logic [XW-1:0] width = 8'd16;
    logic [IV_W-1:0] interval = '0;
    logic [XW-1:0] px = '0;
    logic [YW-1:0] py = '0;
    logic [XW-1:0] ax = 8'd1;
    logic [YW-1:0] ay = 4'd1;
    logic [XW-1:0] bx = 8'd3;
    logic [YW-1:0] by = 4'd2;
    logic [23:0] fg = 24'h123456;
    logic [23:0] bg = 24'hA0B0C0;
    logic frame_start;
    logic [31:0] pixel;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    vidpat_source #(.XW(XW), .YW(YW), .MODE_W(MODE_W), .IV_W(IV_W)) i_vidpat_source (
        .clk(clk), .rst(rst), .enable_i(enable), .rgb_swap_i(swap), .mode_i(mode),
        .width_i(width), .interval_i(interval), .x_i(px), .y_i(py),
        .corner_ax_i(ax), .corner_ay_i(ay), .corner_bx_i(bx), .corner_by_i(by),
        .fg_rgb_i(fg), .bg_rgb_i(bg), .frame_start_o(frame_start), .pixel_o(pixel)
    );

    function automatic logic [23:0] bar_rgb(int idx);
        case (idx)
            0: return 24'h000000;
            1: return 24'hFF0000;
            2: return 24'hFFA500;
            3: return 24'hFFFF00;
            4: return 24'h00FF00;
            5: return 24'h0000FF;
            6: return 24'h800080;
            default: return 24'hFFFFFF;
        endcase
    endfunction

    function automatic logic [31:0] ref_pix(int m, int x, int y);
        logic [23:0] c;
        int bw;
        int idx;
        c = 24'h0;
        case (m)
            0: c = 24'h000000;
            1: c = 24'hFFFFFF;
            2: c = 24'hFF0000;
            3: c = 24'h00FF00;
            4: c = 24'h0000FF;
            5: begin
                bw = int'(width) / 8;
                idx = (bw == 0) ? 7 : x / bw;
                if (idx > 7) idx = 7;
                c = bar_rgb(idx);
            end
            6: c = (x >= int'(ax) && x <= int'(bx) && y >= int'(ay) && y <= int'(by)) ? fg : bg;
            7: c = {3{8'(x)}};
            default: c = 24'h0;
        endcase
        if (swap) return {8'hFF, c[7:0], c[15:8], c[23:16]};
        return {8'hFF, c};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // Drive one coordinate and sample the registered word one edge later.
    task automatic probe(input int m, input int x, input int y, input string req);
        logic [31:0] e;
        mode = MODE_W'(m);
        px = XW'(x);
        py = YW'(y);
        e = ref_pix(m, x, y);
        @(negedge clk);
        check(pixel === e, req, pixel, e);
    endtask

    // Enable with period iv for n cycles, then disable; the count starts from zero.
    task automatic run_timer(input int iv, input int n);
        int eff;
        bit e;
        eff = (iv < 2) ? 2 : iv;
        interval = IV_W'(iv);
        enable = 1'b1;
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            e = ((k % eff) == 0);
            check(frame_start === e, (iv < 2) ? "R4" : "R2", {31'b0, frame_start}, {31'b0, e});
        end
        enable = 1'b0;
        @(negedge clk);
        check(frame_start === 1'b0, "R3", {31'b0, frame_start}, 32'h0);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(frame_start === 1'b0, "R1", {31'b0, frame_start}, 32'h0);
        check(pixel === 32'hFF000000, "R1", pixel, 32'hFF000000);
        rst = 1'b0;

        // R5 R6 R7 R8 R9 R10 R11: every code over a 16x4 frame in both lane orders
        for (int s = 0; s < 2; s++) begin
            swap = s[0];
            for (int m = 0; m < 16; m++)
                for (int y = 0; y < 4; y++)
                    for (int x = 0; x < 16; x++)
                        probe(m, x, y, (s == 1) ? "R11" : (m < 5) ? "R5" : (m == 5) ? "R6" :
                              (m == 6) ? "R7" : (m == 7) ? "R8" : "R9");
        end
        swap = 1'b0;

        // R7: white square on black, inclusive corners (1,1)-(3,2)
        fg = 24'hFFFFFF;
        bg = 24'h000000;
        for (int y = 0; y < 4; y++)
            for (int x = 0; x < 6; x++)
                probe(6, x, y, "R7");
        // R7: corners reversed give an empty rectangle
        ax = 8'd4; bx = 8'd2;
        for (int x = 0; x < 8; x++) probe(6, x, 1, "R7");
        ax = 8'd1; bx = 8'd3;

        // R6: other widths, columns past the last full bar, too-narrow width
        width = 8'd20;
        for (int x = 0; x < 32; x++) probe(5, x, 0, "R6");
        width = 8'd64;
        for (int x = 0; x < 64; x++) probe(5, x, 2, "R6");
        width = 8'd8;
        for (int x = 0; x < 12; x++) probe(5, x, 0, "R6");
        width = 8'd5;
        for (int x = 0; x < 6; x++) probe(5, x, 0, "R6");

        // R8: whole ramp in both lane orders
        for (int s = 0; s < 2; s++) begin
            swap = s[0];
            for (int x = 0; x < 256; x++) probe(7, x, 3, "R8");
        end
        swap = 1'b0;

        // R10: word follows the previous edge, not the current inputs
        mode = 4'd2;
        @(negedge clk);
        mode = 4'd4;
        #1;
        check(pixel === 32'hFFFF0000, "R10", pixel, 32'hFFFF0000);
        @(negedge clk);
        check(pixel === 32'hFF0000FF, "R10", pixel, 32'hFF0000FF);

        // R3: disabled timer stays quiet
        interval = 5'd2;
        enable = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check(frame_start === 1'b0, "R3", {31'b0, frame_start}, 32'h0);
        end

        // R2 R4: periods 0..12, three frames each
        for (int iv = 0; iv <= 12; iv++) run_timer(iv, 3 * ((iv < 2) ? 2 : iv) + 1);

        // R3: interrupted count restarts from zero
        run_timer(6, 4);
        run_timer(6, 13);
        run_timer(31, 33);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule